// File: doc/BRIEF.md
# Packed Unsigned Saturating Subtractor

This block is a SIMD execution slice that subtracts a packed source operand from a packed destination operand, one lane at a time. A lane whose difference would go below zero produces zero rather than wrapping around. A lane whose difference is zero or positive produces the exact unsigned difference. The value that comes back is the new destination value. The block raises no status flags and signals no exceptions.

Two run-time selects set the lane layout. Bit 0 of the opcode byte picks the lane size: byte lanes (opcode D8h) or 16-bit word lanes (opcode D9h). An operand-size prefix flag picks between a 128-bit operation and a 64-bit operation. A 64-bit operation works on the low half only and drives the high half of the result to zero.

The result and a valid flag are registered. The result appears one clock after the input strobe.

Top module: `psat_sub_unit`

## Requirements
- R1: In byte mode, every byte lane with dst >= src returns exactly dst - src, where dst is the first operand and src is the second.
- R2: In byte mode, every byte lane with dst < src returns 8'h00.
- R3: In word mode, every 16-bit lane with dst < src returns 16'h0000.
- R4: In word mode, every 16-bit lane with dst >= src returns the exact 16-bit difference. A borrow from the low byte of a word reaches that word's high byte (0100h - 0001h = 00FFh).
- R5: A borrow never crosses a lane boundary. In byte mode, lanes 0100h - 0001h give 0100h, not 00FFh.
- R6: Only bit 0 of `op_byte` is decoded: 0 selects byte lanes and 1 selects word lanes (D8h is byte, D9h is word). The other opcode bits have no effect.
- R7: With `wide_pfx` = 1, all 128 bits are processed (16 byte lanes or 8 word lanes). With `wide_pfx` = 0, only bits 63:0 are processed (8 byte lanes or 4 word lanes), `res[127:64]` is zero, and `dst`/`src` bits 127:64 are ignored.
- R8: A strobe on `in_valid` at one rising edge shows up as `res_valid` = 1 with the new `res` after that edge. `res_valid` is 0 after any edge at which `in_valid` was 0.
- R9: While `in_valid` is 0, `res` keeps its last value whatever `dst`, `src`, `op_byte` and `wide_pfx` do.
- R10: A synchronous active-high `rst` clears `res` to zero and `res_valid` to 0. Reset wins over a strobe in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| wide_pfx | input | 1 | 1: 128-bit operation, 0: 64-bit operation |
| op_byte | input | 8 | Opcode byte; bit 0 selects byte (0) or word (1) lanes |
| dst | input | 128 | Minuend (first operand) |
| src | input | 128 | Subtrahend (second operand) |
| res | output | 128 | Registered saturated difference |
| res_valid | output | 1 | Result valid, one cycle after the strobe |

## Verification
The properties compare each result lane with the operands captured at the strobe edge. They therefore assume that `dst`, `src`, `op_byte` and `wide_pfx` are settled at that edge, and that `in_valid` is never unknown once reset is released. The stimulus changes every input only on falling clock edges and always drives defined values. It also changes operands while `in_valid` is low, which exercises the hold behaviour without breaking those assumptions.

// File: rtl/psat_pkg.sv
package psat_pkg;
   typedef enum logic {
      LANE_BYTE = 1'b0,
      LANE_WORD = 1'b1
   } lane_sz_e;

   typedef struct packed {
      lane_sz_e lsz;
      logic     wide;
   } op_mode_t;
endpackage

// File: rtl/psat_decode.sv
module psat_decode
   import psat_pkg::*;
#(
   parameter int OP_W = 8
) (
   input  logic [OP_W-1:0] op_byte,
   input  logic            wide_pfx,
   output op_mode_t        mode
);
   if (OP_W < 1) begin : g_bad_op
      $error("psat_decode: OP_W must be at least 1");
   end

   always_comb begin
      mode.lsz  = lane_sz_e'(op_byte[0]);
      mode.wide = wide_pfx;
   end
endmodule

// File: rtl/psat_slice.sv
module psat_slice #(
   parameter int SLICE_W = 8
) (
   input  logic [SLICE_W-1:0] a,
   input  logic [SLICE_W-1:0] b,
   input  logic               bin,
   output logic [SLICE_W-1:0] diff,
   output logic               bout
);
   localparam int EXT_W = SLICE_W + 1;
   logic [EXT_W-1:0] ext;

   always_comb begin
      ext  = {1'b0, a} - {1'b0, b} - {{SLICE_W{1'b0}}, bin};
      diff = ext[SLICE_W-1:0];
      bout = ext[SLICE_W];
   end
endmodule

// File: rtl/psat_lane_array.sv
module psat_lane_array
   import psat_pkg::*;
#(
   parameter int DATA_W  = 128,
   parameter int SLICE_W = 8
) (
   input  logic [DATA_W-1:0] dst,
   input  logic [DATA_W-1:0] src,
   input  op_mode_t          mode,
   output logic [DATA_W-1:0] res
);
   localparam int NSLICE   = DATA_W / SLICE_W;
   localparam int HALF_SLC = NSLICE / 2;

   logic [NSLICE-1:0] bout;
   logic [NSLICE-1:0] bin;
   logic [NSLICE-1:0] lane_neg;

   for (genvar s = 0; s < NSLICE; s++) begin : g_slc
      localparam int HI = ((s % 2) == 1) ? s : s + 1;
      localparam bit UPPER = (s >= HALF_SLC);
      logic [SLICE_W-1:0] diff;

      if ((s % 2) == 1) begin : g_odd
         assign bin[s] = (mode.lsz == LANE_WORD) ? bout[s-1] : 1'b0;
      end else begin : g_even
         assign bin[s] = 1'b0;
      end

      psat_slice #(.SLICE_W(SLICE_W)) u_slice (
         .a    (dst[s*SLICE_W +: SLICE_W]),
         .b    (src[s*SLICE_W +: SLICE_W]),
         .bin  (bin[s]),
         .diff (diff),
         .bout (bout[s])
      );

      assign lane_neg[s] = (mode.lsz == LANE_WORD) ? bout[HI] : bout[s];

      if (UPPER) begin : g_upper
         assign res[s*SLICE_W +: SLICE_W] =
            (lane_neg[s] || !mode.wide) ? '0 : diff;
      end else begin : g_lower
         assign res[s*SLICE_W +: SLICE_W] = lane_neg[s] ? '0 : diff;
      end
   end
endmodule

// File: rtl/psat_out_reg.sv
module psat_out_reg #(
   parameter int DATA_W = 128
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ld,
   input  logic [DATA_W-1:0] d,
   output logic [DATA_W-1:0] q,
   output logic              vld
);
   always_ff @(posedge clk) begin
      if (rst) begin
         q   <= '0;
         vld <= 1'b0;
      end else begin
         vld <= ld;
         if (ld) q <= d;
      end
   end
endmodule

// File: rtl/psat_sub_unit.sv
module psat_sub_unit
   import psat_pkg::*;
#(
   parameter int DATA_W  = 128,
   parameter int SLICE_W = 8,
   parameter int OP_W    = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic              wide_pfx,
   input  logic [OP_W-1:0]   op_byte,
   input  logic [DATA_W-1:0] dst,
   input  logic [DATA_W-1:0] src,
   output logic [DATA_W-1:0] res,
   output logic              res_valid
);
   localparam int WORD_W = 2 * SLICE_W;

   if ((DATA_W % (2 * WORD_W)) != 0) begin : g_bad_width
      $error("psat_sub_unit: DATA_W must be a multiple of 4*SLICE_W");
   end
   if (SLICE_W < 1) begin : g_bad_slice
      $error("psat_sub_unit: SLICE_W must be positive");
   end

   op_mode_t          mode;
   logic [DATA_W-1:0] sat_res;

   psat_decode #(.OP_W(OP_W)) u_dec (
      .op_byte  (op_byte),
      .wide_pfx (wide_pfx),
      .mode     (mode)
   );

   psat_lane_array #(.DATA_W(DATA_W), .SLICE_W(SLICE_W)) u_lanes (
      .dst  (dst),
      .src  (src),
      .mode (mode),
      .res  (sat_res)
   );

   psat_out_reg #(.DATA_W(DATA_W)) u_oreg (
      .clk (clk),
      .rst (rst),
      .ld  (in_valid),
      .d   (sat_res),
      .q   (res),
      .vld (res_valid)
   );
endmodule

// File: rtl/psat_sub_unit_chk.sv
module psat_sub_unit_chk #(
   parameter int DATA_W  = 128,
   parameter int SLICE_W = 8,
   parameter int OP_W    = 8
) (
   input logic              clk,
   input logic              rst,
   input logic              in_valid,
   input logic              wide_pfx,
   input logic [OP_W-1:0]   op_byte,
   input logic [DATA_W-1:0] dst,
   input logic [DATA_W-1:0] src,
   input logic [DATA_W-1:0] res,
   input logic              res_valid
);
   localparam int WORD_W = 2 * SLICE_W;
   localparam int NB     = DATA_W / SLICE_W;
   localparam int NW     = DATA_W / WORD_W;
   localparam int HALF   = DATA_W / 2;

   AST_RESET_CLEAR: assert property (@(posedge clk)
      rst |=> (res == '0 && !res_valid)); // R10

   AST_VALID_STROBE: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> res_valid); // R8

   AST_VALID_IDLE: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !res_valid); // R8

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(res)); // R9

   AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !wide_pfx) |=> (res[DATA_W-1:HALF] == '0)); // R7

   for (genvar i = 0; i < NB; i++) begin : g_bchk
      localparam bit LOW = (i < NB / 2);
      AST_BYTE_NOT_ABOVE_DST: assert property (@(posedge clk) disable iff (rst)
         (in_valid && !op_byte[0] && (wide_pfx || LOW)) |=>
         (res[i*SLICE_W +: SLICE_W] <= $past(dst[i*SLICE_W +: SLICE_W]))); // R1
      AST_BYTE_CLAMP: assert property (@(posedge clk) disable iff (rst)
         (in_valid && !op_byte[0] && (wide_pfx || LOW) &&
          dst[i*SLICE_W +: SLICE_W] < src[i*SLICE_W +: SLICE_W]) |=>
         (res[i*SLICE_W +: SLICE_W] == '0)); // R2
   end

   for (genvar w = 0; w < NW; w++) begin : g_wchk
      localparam bit LOW = (w < NW / 2);
      AST_WORD_CLAMP: assert property (@(posedge clk) disable iff (rst)
         (in_valid && op_byte[0] && (wide_pfx || LOW) &&
          dst[w*WORD_W +: WORD_W] < src[w*WORD_W +: WORD_W]) |=>
         (res[w*WORD_W +: WORD_W] == '0)); // R3
      AST_WORD_NOT_ABOVE_DST: assert property (@(posedge clk) disable iff (rst)
         (in_valid && op_byte[0] && (wide_pfx || LOW)) |=>
         (res[w*WORD_W +: WORD_W] <= $past(dst[w*WORD_W +: WORD_W]))); // R4
   end
endmodule

bind psat_sub_unit psat_sub_unit_chk #(
   .DATA_W  (DATA_W),
   .SLICE_W (SLICE_W),
   .OP_W    (OP_W)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .in_valid  (in_valid),
   .wide_pfx  (wide_pfx),
   .op_byte   (op_byte),
   .dst       (dst),
   .src       (src),
   .res       (res),
   .res_valid (res_valid)
);

// File: tb/psat_sub_unit_test.sv
module psat_sub_unit_test;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 8;

   typedef struct packed {
      logic [7:0]   op;
      logic         wide;
      logic [127:0] d;
      logic [127:0] s;
      logic [127:0] e;
   } vec_t;

   localparam vec_t TV [NVEC] = '{
      '{8'hD8, 1'b1, 128'h80808080_80808080_80808080_80808080,
        128'h01020304_05060708_FF7F8081_00102030,
        128'h7F7E7D7C_7B7A7978_00010000_80706050},
      '{8'hD9, 1'b1, 128'h80808080_80808080_80808080_80808080,
        128'h01020304_05060708_FF7F8081_00102030,
        128'h7F7E7D7C_7B7A7978_00000000_80706050},
      '{8'hD9, 1'b1, 128'h01000100_01000100_01000100_01000100,
        128'h00010001_00010001_00010001_00010001,
        128'h00FF00FF_00FF00FF_00FF00FF_00FF00FF},
      '{8'hD8, 1'b1, 128'h01000100_01000100_01000100_01000100,
        128'h00010001_00010001_00010001_00010001,
        128'h01000100_01000100_01000100_01000100},
      '{8'hD8, 1'b0, 128'hFFFFFFFF_FFFFFFFF_11223344_55667788,
        128'h00000000_00000000_01010101_01010101,
        128'h00000000_00000000_10213243_54657687},
      '{8'hD9, 1'b0, 128'hFFFFFFFF_FFFFFFFF_11223344_55667788,
        128'h00000000_00000000_01010101_01010101,
        128'h00000000_00000000_10213243_54657687},
      '{8'h19, 1'b1, 128'h01000100_01000100_01000100_01000100,
        128'h00010001_00010001_00010001_00010001,
        128'h00FF00FF_00FF00FF_00FF00FF_00FF00FF},
      '{8'h58, 1'b1, 128'h01000100_01000100_01000100_01000100,
        128'h00010001_00010001_00010001_00010001,
        128'h01000100_01000100_01000100_01000100}
   };

   localparam string VTAG [NVEC] = '{
      "R1 R2 byte wide", "R3 R4 word wide", "R4 word borrow",
      "R5 byte no cross", "R7 narrow byte", "R7 narrow word",
      "R6 op 19h word", "R6 op 58h byte"};

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         in_valid = 1'b0;
   logic         wide_pfx = 1'b0;
   logic [7:0]   op_byte = 8'h00;
   logic [127:0] dst = '0;
   logic [127:0] src = '0;
   logic [127:0] res;
   logic         res_valid;

   int n_chk = 0;
   int n_fail = 0;

   psat_sub_unit uut (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid),
      .wide_pfx  (wide_pfx),
      .op_byte   (op_byte),
      .dst       (dst),
      .src       (src),
      .res       (res),
      .res_valid (res_valid)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   function automatic logic [127:0] ref_sub(logic [7:0] op, logic wide,
                                            logic [127:0] d, logic [127:0] s);
      logic [127:0] r;
      logic [15:0]  dl, sl, df;
      int lw, n;
      r  = '0;
      lw = op[0] ? 16 : 8;
      n  = (wide ? 128 : 64) / lw;
      for (int l = 0; l < n; l++) begin
         dl = 16'(d >> (l * lw));
         sl = 16'(s >> (l * lw));
         if (lw == 8) begin
            dl[15:8] = 8'h00;
            sl[15:8] = 8'h00;
         end
         df = (dl >= sl) ? dl - sl : 16'h0000;
         r  = r | (128'(df) << (l * lw));
      end
      return r;
   endfunction

   task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic apply(logic [7:0] op, logic wide, logic [127:0] d,
                        logic [127:0] s);
      @(negedge clk);
      op_byte  = op;
      wide_pfx = wide;
      dst      = d;
      src      = s;
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic finish_run();
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   initial begin
      logic [127:0] held;
      repeat (3) @(negedge clk);
      check("R10 reset res", res, '0);
      check("R10 reset valid", 128'(res_valid), 128'(0));
      rst = 1'b0;

      for (int v = 0; v < NVEC; v++) begin
         apply(TV[v].op, TV[v].wide, TV[v].d, TV[v].s);
         check(VTAG[v], res, TV[v].e);
         check("R8 valid after strobe", 128'(res_valid), 128'(1));
      end

      // R9 R8: idle cycles hold result, valid drops
      held = res;
      dst  = {4{32'h12345678}};
      src  = '0;
      op_byte  = 8'hD9;
      wide_pfx = 1'b1;
      @(negedge clk);
      check("R8 valid idle", 128'(res_valid), 128'(0));
      check("R9 hold while idle", res, held);
      @(negedge clk);
      check("R9 hold second idle", res, held);

      // R2 R3: full clamp of all lanes
      apply(8'hD8, 1'b1, '0, {16{8'h01}});
      check("R2 all bytes clamp", res, '0);
      apply(8'hD9, 1'b1, {8{16'h00FF}}, {8{16'h0100}});
      check("R3 all words clamp", res, '0);

      // R1: equal and max operands
      apply(8'hD8, 1'b1, {16{8'hFF}}, {16{8'hFF}});
      check("R1 equal gives zero", res, '0);
      apply(8'hD8, 1'b1, {16{8'hFF}}, '0);
      check("R1 zero subtrahend", res, {16{8'hFF}});

      // R7: narrow word ignores upper inputs including clamps there
      apply(8'hD9, 1'b0, {{4{16'h0000}}, {4{16'hFFFF}}},
            {{4{16'hFFFF}}, {4{16'h0001}}});
      check("R7 narrow ignores upper", res, {64'h0, {4{16'hFFFE}}});

      // R4 R1: seeded mixed patterns against reference model
      for (int k = 0; k < 40; k++) begin
         logic [127:0] d, s;
         logic [7:0]   op;
         logic         wd;
         d  = {$urandom, $urandom, $urandom, $urandom};
         s  = {$urandom, $urandom, $urandom, $urandom};
         op = 8'(k[0] ? 8'hD9 : 8'hD8);
         wd = k[1];
         apply(op, wd, d, s);
         check("R1 R4 mixed pattern", res, ref_sub(op, wd, d, s));
      end

      // R10: reset wins over a strobe in the same cycle
      @(negedge clk);
      rst      = 1'b1;
      in_valid = 1'b1;
      op_byte  = 8'hD8;
      wide_pfx = 1'b1;
      dst      = {16{8'h55}};
      src      = '0;
      @(negedge clk);
      check("R10 reset over strobe res", res, '0);
      check("R10 reset over strobe valid", 128'(res_valid), 128'(0));
      rst      = 1'b0;
      in_valid = 1'b0;
      @(negedge clk);
      finish_run();
   end
endmodule